// File: doc/BRIEF.md
# Register-bus to MAC host bridge

This block lets a processor on a simple register bus configure two Ethernet MAC instances through their host ports. The processor sees four bridge registers: a low data word, a high data word, a control word and a ready/status word. An access takes two steps. Software first stages a value in the low data word. It then writes the control word, which names the target MAC, gives the direction and carries a compact 4-bit register code. That control write launches one translated host access.

The bridge turns the register code into the MAC's 10-bit host address. It raises a one-cycle request, together with the opcode, the address, the configuration-space select and the write data, on the selected MAC's port only. For a read it waits a fixed, parameterised number of cycles and captures the returned word into the low data word. Each MAC has its own ready flag. The flag drops when a transaction to that MAC is launched and rises when the transaction completes. Data words cross the bridge with no change of bit order.

Top module: `rbus_mac_bridge`

## Requirements
- R1: After reset the low data word, high data word, control word and both ready flags read as zero, and no host request is raised.
- R2: A control write accepted while idle, with a defined code, raises the request on the selected MAC (control bit 10: 0 picks MAC0, 1 picks MAC1) for exactly one cycle, starting the cycle after the write. The other MAC sees no request.
- R3: Register codes (control bits 3:0) 0 to 11 translate in order to host addresses 0x200, 0x240, 0x280, 0x2C0, 0x300, 0x320, 0x340, 0x380, 0x384, 0x388, 0x38C and 0x390.
- R4: With control bit 15 set (write), the opcode is 2'b00 and the host write data equals the low data word staged before the control write. The selected ready flag is set in the cycle after the request.
- R5: With control bit 15 clear (read), the opcode is 2'b10. The bridge captures the selected MAC's read data RD_LAT cycles after the request cycle into the low data word, and sets the selected ready flag in the following cycle, not earlier.
- R6: No bit reordering is applied: a bus word such as 0x8000_0001 appears with that same value on the host write data.
- R7: The configuration-space select output is low whenever a request is raised.
- R8: Launching a transaction clears the selected MAC's ready flag. A control write that arrives while a transaction is in progress is ignored: it raises no request and leaves the control word and the ready flags unchanged.
- R9: Codes 12 to 15 raise no request and set the selected ready flag in the cycle after the control write. For a read, the low data word becomes zero; for a write, it keeps its value.
- R10: The high data word is read/write storage that host transactions never change.
- R11: Bus register offsets are 0 for the low data word, 1 for the high data word, 2 for the control word and 3 for status. In the status word, bit 0 is MAC0 ready and bit 1 is MAC1 ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rb_sel | input | 1 | Bus access strobe |
| rb_wr | input | 1 | Bus write when high, read when low |
| rb_addr | input | 2 | Bus register offset |
| rb_wdata | input | 32 | Bus write data |
| rb_rdata | output | 32 | Bus read data (selected register) |
| host_req | output | 2 | Per-MAC host request |
| host_addr | output | 20 | Per-MAC 10-bit host address (MAC1 in upper half) |
| host_opcode | output | 4 | Per-MAC 2-bit opcode |
| host_mgmt_sel | output | 2 | Per-MAC configuration-space select (low for register access) |
| host_wdata | output | 64 | Per-MAC 32-bit write data |
| host_rdata | input | 64 | Per-MAC 32-bit read data |

## Verification
The bench builds the bridge with RD_LAT set to 3 and the other parameters at their defaults. With that latency the wait counter steps through several values before it captures. A read also stays in progress long enough for a second control write to land inside it and be dropped. The host-side responders drive valid read data only in the exact capture cycle and a junk word in every other cycle, so a capture that comes a cycle early or late returns the wrong value.

// File: rtl/hbr_pkg.sv
package hbr_pkg;

   typedef enum logic [1:0] {
      SQ_IDLE = 2'd0,
      SQ_REQ  = 2'd1,
      SQ_WAIT = 2'd2
   } sq_state_t;

   localparam logic [1:0] OP_WRITE = 2'b00;
   localparam logic [1:0] OP_READ  = 2'b10;

   localparam logic CFG_SPACE_SEL = 1'b0;

   localparam logic [1:0] RB_DATA_LO = 2'd0;
   localparam logic [1:0] RB_DATA_HI = 2'd1;
   localparam logic [1:0] RB_CTRL    = 2'd2;
   localparam logic [1:0] RB_STATUS  = 2'd3;

   // returns {defined, host address}
   function automatic logic [10:0] map_code(input logic [3:0] code);
      logic [10:0] r;
      case (code)
         4'd0:    r = {1'b1, 10'h200};
         4'd1:    r = {1'b1, 10'h240};
         4'd2:    r = {1'b1, 10'h280};
         4'd3:    r = {1'b1, 10'h2C0};
         4'd4:    r = {1'b1, 10'h300};
         4'd5:    r = {1'b1, 10'h320};
         4'd6:    r = {1'b1, 10'h340};
         4'd7:    r = {1'b1, 10'h380};
         4'd8:    r = {1'b1, 10'h384};
         4'd9:    r = {1'b1, 10'h388};
         4'd10:   r = {1'b1, 10'h38C};
         4'd11:   r = {1'b1, 10'h390};
         default: r = {1'b0, 10'h000};
      endcase
      return r;
   endfunction

endpackage

// File: rtl/hbr_code_decode.sv
module hbr_code_decode #(
   parameter int CODE_W  = 4,
   parameter int HADDR_W = 10
) (
   input  logic [CODE_W-1:0]  code,
   output logic [HADDR_W-1:0] addr,
   output logic               defined
);
   import hbr_pkg::*;

   logic [10:0] base;

   initial begin
      assert (CODE_W >= 4) else $error("CODE_W must be at least 4");
      assert (HADDR_W == 10) else $error("HADDR_W must be 10");
   end

   assign base = map_code(code[3:0]);
   assign addr = base[HADDR_W-1:0];

   generate
      if (CODE_W > 4) begin : g_wide
         assign defined = base[10] && (code[CODE_W-1:4] == '0);
      end else begin : g_exact
         assign defined = base[10];
      end
   endgenerate

endmodule

// File: rtl/hbr_sequencer.sv
module hbr_sequencer #(
   parameter int RD_LAT = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic code_ok,
   input  logic is_write,
   output logic busy,
   output logic launch,
   output logic capture,
   output logic done
);
   import hbr_pkg::*;

   localparam int CNT_W = (RD_LAT < 1) ? 1 : $clog2(RD_LAT + 1);

   sq_state_t        state;
   logic [CNT_W-1:0] cnt;
   logic             wr_q;

   initial begin
      assert (RD_LAT >= 1) else $error("RD_LAT must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= SQ_IDLE;
         cnt   <= '0;
         wr_q  <= 1'b0;
      end else begin
         case (state)
            SQ_IDLE: begin
               if (start && code_ok) begin
                  state <= SQ_REQ;
                  wr_q  <= is_write;
               end
            end
            SQ_REQ: begin
               if (wr_q) begin
                  state <= SQ_IDLE;
               end else begin
                  state <= SQ_WAIT;
                  cnt   <= CNT_W'(1);
               end
            end
            SQ_WAIT: begin
               if (cnt == CNT_W'(RD_LAT)) state <= SQ_IDLE;
               else                       cnt   <= cnt + 1'b1;
            end
            default: state <= SQ_IDLE;
         endcase
      end
   end

   assign busy    = (state != SQ_IDLE);
   assign launch  = start && code_ok;
   assign capture = (state == SQ_WAIT) && (cnt == CNT_W'(RD_LAT));
   assign done    = (start && !code_ok) || ((state == SQ_REQ) && wr_q) || capture;

endmodule

// File: rtl/hbr_host_port.sv
module hbr_host_port #(
   parameter int DATA_W  = 32,
   parameter int HADDR_W = 10
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               launch,
   input  logic [HADDR_W-1:0] addr_in,
   input  logic [1:0]         op_in,
   input  logic [DATA_W-1:0]  wdata_in,
   output logic               req,
   output logic [HADDR_W-1:0] addr,
   output logic [1:0]         op,
   output logic               mgmt_sel,
   output logic [DATA_W-1:0]  wdata
);
   import hbr_pkg::*;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req      <= 1'b0;
         addr     <= '0;
         op       <= OP_WRITE;
         mgmt_sel <= CFG_SPACE_SEL;
         wdata    <= '0;
      end else begin
         req <= launch;
         if (launch) begin
            addr     <= addr_in;
            op       <= op_in;
            mgmt_sel <= CFG_SPACE_SEL;
            wdata    <= wdata_in;
         end
      end
   end

endmodule

// File: rtl/rbus_mac_bridge.sv
module rbus_mac_bridge #(
   parameter int DATA_W        = 32,
   parameter int HADDR_W       = 10,
   parameter int CODE_W        = 4,
   parameter int RD_LAT        = 1,
   parameter int CTRL_WEN_BIT  = 15,
   parameter int CTRL_SEL_BIT  = 10,
   parameter int CTRL_CODE_LSB = 0
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  rb_sel,
   input  logic                  rb_wr,
   input  logic [1:0]            rb_addr,
   input  logic [DATA_W-1:0]     rb_wdata,
   output logic [DATA_W-1:0]     rb_rdata,
   output logic [1:0]            host_req,
   output logic [2*HADDR_W-1:0]  host_addr,
   output logic [3:0]            host_opcode,
   output logic [1:0]            host_mgmt_sel,
   output logic [2*DATA_W-1:0]   host_wdata,
   input  logic [2*DATA_W-1:0]   host_rdata
);
   import hbr_pkg::*;

   localparam int NUM_MAC  = 2;
   localparam int CODE_MSB = CTRL_CODE_LSB + CODE_W - 1;

   initial begin
      assert (DATA_W == 32) else $error("DATA_W must be 32");
      assert (CODE_MSB < DATA_W) else $error("code field outside word");
      assert (CTRL_WEN_BIT < DATA_W && CTRL_SEL_BIT < DATA_W) else $error("bit outside word");
      assert (CTRL_WEN_BIT != CTRL_SEL_BIT) else $error("control bits overlap");
      assert (CTRL_WEN_BIT > CODE_MSB || CTRL_WEN_BIT < CTRL_CODE_LSB) else $error("wen overlaps code");
      assert (CTRL_SEL_BIT > CODE_MSB || CTRL_SEL_BIT < CTRL_CODE_LSB) else $error("sel overlaps code");
   end

   logic [DATA_W-1:0]  data_lo_q, data_hi_q, ctrl_q;
   logic [NUM_MAC-1:0] ready_q;
   logic               sel_q;

   logic               wr_lo, wr_hi, wr_ctrl, start;
   logic               new_wen, new_sel, sel_eff;
   logic [CODE_W-1:0]  new_code;
   logic [HADDR_W-1:0] dec_addr;
   logic               dec_ok;
   logic               busy, launch, capture, done;
   logic [DATA_W-1:0]  rd_word;

   assign wr_lo   = rb_sel && rb_wr && (rb_addr == RB_DATA_LO);
   assign wr_hi   = rb_sel && rb_wr && (rb_addr == RB_DATA_HI);
   assign wr_ctrl = rb_sel && rb_wr && (rb_addr == RB_CTRL);
   assign start   = wr_ctrl && !busy;

   assign new_wen  = rb_wdata[CTRL_WEN_BIT];
   assign new_sel  = rb_wdata[CTRL_SEL_BIT];
   assign new_code = rb_wdata[CTRL_CODE_LSB +: CODE_W];
   assign sel_eff  = start ? new_sel : sel_q;

   hbr_code_decode #(
      .CODE_W (CODE_W),
      .HADDR_W(HADDR_W)
   ) i_decode (
      .code   (new_code),
      .addr   (dec_addr),
      .defined(dec_ok)
   );

   hbr_sequencer #(
      .RD_LAT(RD_LAT)
   ) i_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .code_ok (dec_ok),
      .is_write(new_wen),
      .busy    (busy),
      .launch  (launch),
      .capture (capture),
      .done    (done)
   );

   assign rd_word = host_rdata[sel_q*DATA_W +: DATA_W];

   generate
      for (genvar m = 0; m < NUM_MAC; m++) begin : g_mac
         hbr_host_port #(
            .DATA_W (DATA_W),
            .HADDR_W(HADDR_W)
         ) i_port (
            .clk     (clk),
            .rst_n   (rst_n),
            .launch  (launch && (new_sel == 1'(m))),
            .addr_in (dec_addr),
            .op_in   (new_wen ? OP_WRITE : OP_READ),
            .wdata_in(data_lo_q),
            .req     (host_req[m]),
            .addr    (host_addr[m*HADDR_W +: HADDR_W]),
            .op      (host_opcode[m*2 +: 2]),
            .mgmt_sel(host_mgmt_sel[m]),
            .wdata   (host_wdata[m*DATA_W +: DATA_W])
         );
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_lo_q <= '0;
         data_hi_q <= '0;
         ctrl_q    <= '0;
         sel_q     <= 1'b0;
      end else begin
         if (capture)                          data_lo_q <= rd_word;
         else if (start && !dec_ok && !new_wen) data_lo_q <= '0;
         else if (wr_lo)                       data_lo_q <= rb_wdata;
         if (wr_hi) data_hi_q <= rb_wdata;
         if (start) begin
            ctrl_q <= rb_wdata;
            sel_q  <= new_sel;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ready_q <= '0;
      end else begin
         for (int m = 0; m < NUM_MAC; m++) begin
            if (done && (sel_eff == 1'(m)))        ready_q[m] <= 1'b1;
            else if (start && (new_sel == 1'(m))) ready_q[m] <= 1'b0;
         end
      end
   end

   always_comb begin
      case (rb_addr)
         RB_DATA_LO: rb_rdata = data_lo_q;
         RB_DATA_HI: rb_rdata = data_hi_q;
         RB_CTRL:    rb_rdata = ctrl_q;
         default:    rb_rdata = {{(DATA_W-NUM_MAC){1'b0}}, ready_q};
      endcase
   end

endmodule

// File: rtl/hbr_checker.sv
module hbr_checker (
   input logic       clk,
   input logic       rst_n,
   input logic [1:0] host_req,
   input logic [3:0] host_opcode,
   input logic [1:0] host_mgmt_sel,
   input logic [1:0] ready
);
   import hbr_pkg::*;

   // R2: never both MACs at once
   a_r2_one_mac: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(host_req));

   // R2: request lasts one cycle
   a_r2_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      (|host_req) |=> (host_req == 2'b00));

   // R7: configuration space on every request
   a_r7_cfg_space_m0: assert property (@(posedge clk) disable iff (!rst_n)
      host_req[0] |-> (host_mgmt_sel[0] == CFG_SPACE_SEL));
   a_r7_cfg_space_m1: assert property (@(posedge clk) disable iff (!rst_n)
      host_req[1] |-> (host_mgmt_sel[1] == CFG_SPACE_SEL));

   // R8: ready flag low while the request is out
   a_r8_ready_low_m0: assert property (@(posedge clk) disable iff (!rst_n)
      host_req[0] |-> !ready[0]);
   a_r8_ready_low_m1: assert property (@(posedge clk) disable iff (!rst_n)
      host_req[1] |-> !ready[1]);

   // R4: write completes the cycle after the request
   a_r4_write_done_m0: assert property (@(posedge clk) disable iff (!rst_n)
      (host_req[0] && host_opcode[1:0] == OP_WRITE) |=> ready[0]);
   a_r4_write_done_m1: assert property (@(posedge clk) disable iff (!rst_n)
      (host_req[1] && host_opcode[3:2] == OP_WRITE) |=> ready[1]);

   // R5: read still pending the cycle after the request
   a_r5_read_pending_m0: assert property (@(posedge clk) disable iff (!rst_n)
      (host_req[0] && host_opcode[1:0] == OP_READ) |=> !ready[0]);
   a_r5_read_pending_m1: assert property (@(posedge clk) disable iff (!rst_n)
      (host_req[1] && host_opcode[3:2] == OP_READ) |=> !ready[1]);

endmodule

bind rbus_mac_bridge hbr_checker i_hbr_checker (
   .clk          (clk),
   .rst_n        (rst_n),
   .host_req     (host_req),
   .host_opcode  (host_opcode),
   .host_mgmt_sel(host_mgmt_sel),
   .ready        (ready_q)
);

// File: tb/test_rbus_mac_bridge.sv
`timescale 1ns/1ps
module test_rbus_mac_bridge;

   localparam int RD_LAT = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rb_sel = 1'b0, rb_wr = 1'b0;
   logic [1:0]  rb_addr = 2'd0;
   logic [31:0] rb_wdata = '0;
   logic [31:0] rb_rdata;
   logic [1:0]  host_req;
   logic [19:0] host_addr;
   logic [3:0]  host_opcode;
   logic [1:0]  host_mgmt_sel;
   logic [63:0] host_wdata;
   logic [63:0] host_rdata;

   int checks = 0;
   int fails  = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   rbus_mac_bridge #(.RD_LAT(RD_LAT)) i_rbus_mac_bridge (
      .clk(clk), .rst_n(rst_n), .rb_sel(rb_sel), .rb_wr(rb_wr),
      .rb_addr(rb_addr), .rb_wdata(rb_wdata), .rb_rdata(rb_rdata),
      .host_req(host_req), .host_addr(host_addr), .host_opcode(host_opcode),
      .host_mgmt_sel(host_mgmt_sel), .host_wdata(host_wdata),
      .host_rdata(host_rdata)
   );

   // host-side responders and monitors
   int          req_cnt   [2];
   logic [9:0]  last_addr [2];
   logic [1:0]  last_op   [2];
   logic [31:0] last_wd   [2];
   logic        last_mgmt [2];
   logic [RD_LAT-1:0] pipe [2];

   function automatic logic [31:0] resp_word(int m, logic [9:0] a);
      return {(m == 1) ? 16'hB1C2 : 16'hA0D3, 6'h00, a};
   endfunction

   initial begin
      for (int m = 0; m < 2; m++) begin
         req_cnt[m] = 0; last_addr[m] = '0; last_op[m] = '0;
         last_wd[m] = '0; last_mgmt[m] = 1'b0; pipe[m] = '0;
      end
   end

   always @(posedge clk) begin
      for (int m = 0; m < 2; m++) begin
         pipe[m] <= {pipe[m][RD_LAT-2:0], host_req[m]};
         if (host_req[m]) begin
            req_cnt[m]   <= req_cnt[m] + 1;
            last_addr[m] <= host_addr[m*10 +: 10];
            last_op[m]   <= host_opcode[m*2 +: 2];
            last_wd[m]   <= host_wdata[m*32 +: 32];
            last_mgmt[m] <= host_mgmt_sel[m];
         end
      end
   end

   always_comb begin
      for (int m = 0; m < 2; m++)
         host_rdata[m*32 +: 32] = pipe[m][RD_LAT-1] ? resp_word(m, last_addr[m]) : 32'hDEADBEEF;
   end

   function automatic logic [9:0] exp_addr(int code);
      case (code)
         0: return 10'h200;  1: return 10'h240;  2: return 10'h280;
         3: return 10'h2C0;  4: return 10'h300;  5: return 10'h320;
         6: return 10'h340;  7: return 10'h380;  8: return 10'h384;
         9: return 10'h388;  10: return 10'h38C; default: return 10'h390;
      endcase
   endfunction

   function automatic logic [31:0] mk_ctrl(bit wen, bit sel, int code);
      return (32'(wen) << 15) | (32'(sel) << 10) | 32'(code & 15);
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic bus_write(logic [1:0] a, logic [31:0] d);
      @(negedge clk);
      rb_sel = 1'b1; rb_wr = 1'b1; rb_addr = a; rb_wdata = d;
      @(negedge clk);
      rb_sel = 1'b0; rb_wr = 1'b0;
   endtask

   task automatic bus_read(logic [1:0] a, output logic [31:0] d);
      rb_addr = a;
      #1 d = rb_rdata;
   endtask

   task automatic t_reset();
      logic [31:0] v;
      for (int a = 0; a < 4; a++) begin
         bus_read(2'(a), v);
         check("R1 reset register", v, 32'h0);
      end
      check("R1 no request after reset", 32'(host_req), 32'h0);
   endtask

   task automatic t_write(bit mac, int code, logic [31:0] d, string tag);
      logic [31:0] v;
      int c0 = req_cnt[0], c1 = req_cnt[1];
      bus_write(2'd0, d);
      bus_write(2'd2, mk_ctrl(1'b1, mac, code));
      check({tag, " request on selected MAC"}, 32'(host_req), mac ? 32'h2 : 32'h1);
      @(negedge clk); @(negedge clk);
      check({tag, " one request"}, 32'(req_cnt[mac]), 32'(((mac) ? c1 : c0) + 1));
      check({tag, " other MAC idle"}, 32'(req_cnt[!mac]), 32'((mac) ? c0 : c1));
      check({tag, " address"}, 32'(last_addr[mac]), 32'(exp_addr(code)));
      check({tag, " write opcode"}, 32'(last_op[mac]), 32'h0);
      check({tag, " write data"}, last_wd[mac], d);
      check("R7 config select", 32'(last_mgmt[mac]), 32'h0);
      bus_read(2'd3, v);
      check({tag, " ready set"}, 32'(v[mac]), 32'h1);
   endtask

   task automatic t_read(bit mac, int code);
      logic [31:0] v;
      bus_write(2'd2, mk_ctrl(1'b0, mac, code));
      bus_read(2'd3, v);
      check("R8 ready cleared on launch", 32'(v[mac]), 32'h0);
      @(negedge clk); @(negedge clk); @(negedge clk);
      bus_read(2'd3, v);
      check("R5 not ready before capture", 32'(v[mac]), 32'h0);
      @(negedge clk);
      bus_read(2'd3, v);
      check("R5 ready after capture", 32'(v[mac]), 32'h1);
      bus_read(2'd0, v);
      check("R5 captured data", v, resp_word(mac, exp_addr(code)));
      check("R5 read opcode", 32'(last_op[mac]), 32'h2);
      check("R3 read address", 32'(last_addr[mac]), 32'(exp_addr(code)));
   endtask

   task automatic t_busy_ignore();
      logic [31:0] v;
      int c1 = req_cnt[1];
      bus_write(2'd2, mk_ctrl(1'b0, 1'b0, 2));
      bus_write(2'd2, mk_ctrl(1'b1, 1'b1, 3));
      repeat (RD_LAT + 3) @(negedge clk);
      check("R8 dropped write no request", 32'(req_cnt[1]), 32'(c1));
      bus_read(2'd2, v);
      check("R8 control word kept", v, mk_ctrl(1'b0, 1'b0, 2));
      bus_read(2'd3, v);
      check("R8 MAC1 ready unchanged", 32'(v[1]), 32'h1);
      bus_read(2'd0, v);
      check("R8 first read completed", v, resp_word(0, 10'h280));
   endtask

   task automatic t_undefined();
      logic [31:0] v;
      int c0 = req_cnt[0], c1 = req_cnt[1];
      bus_write(2'd0, 32'h1234_5678);
      bus_write(2'd2, mk_ctrl(1'b0, 1'b0, 13));
      bus_read(2'd3, v);
      check("R9 ready set at once", 32'(v[0]), 32'h1);
      bus_read(2'd0, v);
      check("R9 undefined read returns zero", v, 32'h0);
      bus_write(2'd0, 32'h0BAD_F00D);
      bus_write(2'd2, mk_ctrl(1'b1, 1'b1, 15));
      bus_read(2'd3, v);
      check("R9 ready set on write", 32'(v[1]), 32'h1);
      bus_read(2'd0, v);
      check("R9 undefined write keeps data", v, 32'h0BAD_F00D);
      @(negedge clk); @(negedge clk);
      check("R9 no request MAC0", 32'(req_cnt[0]), 32'(c0));
      check("R9 no request MAC1", 32'(req_cnt[1]), 32'(c1));
      t_write(1'b1, 4, 32'h5555_AAAA, "R9 accepted after undefined");
   endtask

   task automatic t_high();
      logic [31:0] v;
      bus_write(2'd1, 32'hC0FF_EE01);
      bus_read(2'd1, v);
      check("R11 high word offset", v, 32'hC0FF_EE01);
      t_read(1'b1, 11);
      bus_read(2'd1, v);
      check("R10 high word untouched", v, 32'hC0FF_EE01);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_write(1'b0, 0, 32'h8000_0001, "R6");
      t_write(1'b1, 5, 32'h0000_00F0, "R6");
      for (int c = 0; c < 12; c++) t_write(c[0], c, 32'hA000_0000 | 32'(c), "R3");
      t_write(1'b0, 2, 32'h1357_9BDF, "R4");
      t_write(1'b1, 7, 32'h2468_ACE0, "R2");
      t_read(1'b0, 1);
      t_read(1'b1, 9);
      t_busy_ignore();
      t_undefined();
      t_high();
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule